// File: doc/BRIEF.md
# Two-Wire Slave Command Engine

This block is the serial front end of a small register device on a two-wire bus. It runs on a fast system clock. The clock and data lines are brought into that domain through flop synchronisers, and line conditions are found from edges of the synchronised copies. A transaction opens when the data line falls while the clock line is high, and it closes when the data line rises while the clock line is high. The first byte names the device. It carries a fixed prefix, three bits that are compared with the strap pins, and a direction bit. The second byte sets an internal register pointer.

A write carries exactly one data byte. For a small set of addresses that take effect at once, the byte goes to the register bank as a one-cycle write strobe. A separate one-cycle commit strobe marks the bus STOP that closes any accepted write, so that the bank can start slower storage. A read first sets the pointer with a write-style header, then sends a repeated START and a read header. The engine then sends bytes from the bank for as long as the master acknowledges each one. The pointer advances after every byte and returns to zero after a configurable top address.

The data line is never driven high. The engine only raises `sda_oe`, which pulls the line low, to acknowledge a byte or to send a 0 bit. A write-permit input and a busy input gate what the engine will accept.

Top module: `tws_cmd_engine`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new transaction from any state, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the engine to idle. Bits clocked in while idle get no acknowledge.
- R2: The first byte after START is taken MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal `strap_addr[2:0]`. Bit 0 gives the direction: 1 is read, 0 is write. On a match the engine holds `sda_oe` high through the ninth clock. On a mismatch it leaves SDA released and stays idle until the next START.
- R3: After a write header, the engine acknowledges the next byte and loads it into the pointer. `reg_addr` shows the pointer.
- R4: When `wr_permit` is 1, the data byte that follows the address byte is acknowledged.
- R5: When the pointer is 0, 1, 2, 3 or 8, an accepted data byte produces a single-cycle `reg_we`, with `reg_addr` and `reg_wdata` valid. The strobe comes in the cycle after the synchronised SCL falling edge that ends the data LSB. Other addresses produce no `reg_we`.
- R6: When `wr_permit` is 0, the data byte is not acknowledged and produces neither `reg_we` nor `commit_stb`. The engine goes idle.
- R7: `commit_stb` is a single-cycle pulse on the STOP that closes a write whose data byte was accepted, at any address. `reg_addr` and `reg_wdata` still hold that write.
- R8: After a read header, the engine sends the byte `reg_rdata` returns for the current pointer, MSB first. It pulls SDA low for each 0 bit.
- R9: The pointer advances by one after each byte sent. When it is at 8, the next value is 0.
- R10: A master ACK (SDA low in the ninth clock) after a read byte starts the next byte. A master NACK releases SDA and returns the engine to idle.
- R11: While `busy_i` is high, START is ignored, no byte is acknowledged and `sda_oe` stays low.
- R12: After an accepted data byte, any further bytes before STOP get no acknowledge and produce no `reg_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_addr | input | 3 | Device select straps compared with ID bits 3..1 |
| wr_permit | input | 1 | 1 allows write data to be accepted |
| busy_i | input | 1 | 1 while the device cannot take transactions |
| reg_addr | output | 8 | Register pointer presented to the bank |
| reg_wdata | output | 8 | Last accepted write data byte |
| reg_we | output | 1 | One-cycle write strobe for immediate addresses |
| reg_rdata | input | 8 | Bank read data for `reg_addr` |
| commit_stb | output | 1 | One-cycle pulse on STOP after an accepted write |

## Verification
The bench drives a bit-level bus master against the engine. The mix covers matching and mismatched headers, write data to immediate and deferred addresses, write-protected writes, surplus data bytes, and reads of one to four bytes that start on either side of the wrap address. Immediate versus deferred addresses are told apart by counting `reg_we` and `commit_stb` pulses. Reads that start at 7 or 8 separate a pointer that wraps after 8 from one that runs on to 9. A master NACK followed by one extra clock shows whether the engine really let go of the line. Seeded random transactions, mixing all of these with random data and random permits, are checked against a register model kept in the bench.

// File: rtl/tws_pkg.sv
package tws_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

   // Transaction phases of the command engine
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ID,
      ST_ID_ACK,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_HOLD,
      ST_RDATA,
      ST_RD_ACK
   } tws_state_e;

endpackage

// File: rtl/tws_sync.sv
// Multi-line, multi-stage flop synchroniser with a selectable reset level.
module tws_sync #(
   parameter int unsigned        LINES   = 2,
   parameter int unsigned        STAGES  = 2,
   parameter logic [LINES-1:0]   RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] d,
   output logic [LINES-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tws_sync: STAGES must be at least 2");
   end
   if (LINES < 1) begin : g_bad_lines
      $error("tws_sync: LINES must be at least 1");
   end

   logic [STAGES-1:0][LINES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/tws_cond.sv
// Edge and bus-condition detector on synchronised SCL/SDA.
module tws_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   // SDA moves while SCL stays high across both samples
   assign start_det =  scl_s & scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s & scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/tws_ptr.sv
// Register pointer with load and wrapping increment.
module tws_ptr #(
   parameter int unsigned AW   = 8,
   parameter int unsigned WRAP = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] ptr
);

   localparam int unsigned TOP    = (1 << AW) - 1;
   localparam logic [AW-1:0] WRAP_V = AW'(WRAP);

   if (WRAP > TOP) begin : g_bad_wrap
      $error("tws_ptr: WRAP does not fit in AW bits");
   end

   logic [AW-1:0] ptr_next;

   if (WRAP == TOP) begin : g_natural_wrap
      assign ptr_next = ptr + 1'b1;
   end else begin : g_compare_wrap
      assign ptr_next = (ptr == WRAP_V) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (load) begin
         ptr <= load_val;
      end else if (step) begin
         ptr <= ptr_next;
      end
   end

endmodule

// File: rtl/tws_cmd_engine.sv
// Two-wire slave command engine: header decode, pointer, one-byte write,
// streaming read, open-drain drive enable.
module tws_cmd_engine
   import tws_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned STRAP_W     = 3,
   parameter logic [6:0]  ID_PREFIX   = 7'h0A,
   parameter int unsigned WRAP_ADDR   = 8,
   parameter logic [15:0] IMM_MASK    = 16'h010F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [2:0]        strap_addr,
   input  logic              wr_permit,
   input  logic              busy_i,
   output logic [7:0]        reg_addr,
   output logic [7:0]        reg_wdata,
   output logic              reg_we,
   input  logic [7:0]        reg_rdata,
   output logic              commit_stb
);

   localparam int unsigned PFX_W = BYTE_W - 1 - STRAP_W;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   if (ADDR_W != BYTE_W) begin : g_bad_addr_w
      $error("tws_cmd_engine: ADDR_W must equal the byte width");
   end
   if (STRAP_W != 3) begin : g_bad_strap_w
      $error("tws_cmd_engine: STRAP_W must match the strap port width");
   end
   if (PFX_W < 1) begin : g_bad_prefix
      $error("tws_cmd_engine: no room left for the ID prefix");
   end

   // ---------------- line conditioning ----------------
   logic [1:0] sync_q;
   logic       scl_s, sda_s;
   logic       scl_rise, scl_fall, start_det, stop_det;

   tws_sync #(
      .LINES   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b11)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (sync_q)
   );

   assign {scl_s, sda_s} = sync_q;

   tws_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   // ---------------- engine state ----------------
   tws_state_e        state;
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   logic              rw_q;
   logic              mack_q;
   logic              wr_done;
   logic              oe_q;
   logic              we_q;
   logic              commit_q;
   logic [BYTE_W-1:0] wdata_q;
   logic [ADDR_W-1:0] ptr;

   logic evt_ok;
   logic byte_end;
   logic ptr_load;
   logic ptr_step;
   logic id_hit;

   function automatic logic imm_hit(input logic [ADDR_W-1:0] a);
      return (a < ADDR_W'(16)) && IMM_MASK[a[3:0]];
   endfunction

   assign evt_ok   = !busy_i && !start_det && !stop_det;
   assign byte_end = scl_fall && (bitcnt == LAST_BIT);
   assign ptr_load = evt_ok && (state == ST_ADDR)  && byte_end;
   assign ptr_step = evt_ok && (state == ST_RDATA) && byte_end;
   assign id_hit   = (rx_sh[BYTE_W-1 -: PFX_W] == ID_PREFIX[PFX_W-1:0]) &&
                     (rx_sh[STRAP_W:1] == strap_addr);

   tws_ptr #(
      .AW   (ADDR_W),
      .WRAP (WRAP_ADDR)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (rx_sh[ADDR_W-1:0]),
      .step     (ptr_step),
      .ptr      (ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         rw_q     <= 1'b0;
         mack_q   <= 1'b0;
         wr_done  <= 1'b0;
         oe_q     <= 1'b0;
         we_q     <= 1'b0;
         commit_q <= 1'b0;
         wdata_q  <= '0;
      end else begin
         we_q     <= 1'b0;
         commit_q <= 1'b0;
         if (busy_i) begin
            state   <= ST_IDLE;
            oe_q    <= 1'b0;
            wr_done <= 1'b0;
         end else if (start_det) begin
            state   <= ST_ID;
            bitcnt  <= '0;
            oe_q    <= 1'b0;
            wr_done <= 1'b0;
         end else if (stop_det) begin
            state    <= ST_IDLE;
            oe_q     <= 1'b0;
            commit_q <= wr_done;
            wr_done  <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: begin
               end
               ST_ID, ST_ADDR, ST_WDATA: begin
                  if (scl_rise) begin
                     rx_sh  <= {rx_sh[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (byte_end) begin
                     bitcnt <= '0;
                     if (state == ST_ID) begin
                        if (id_hit) begin
                           oe_q  <= 1'b1;
                           rw_q  <= rx_sh[0];
                           state <= ST_ID_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_ADDR) begin
                        oe_q  <= 1'b1;
                        state <= ST_ADDR_ACK;
                     end else if (wr_permit) begin
                        oe_q    <= 1'b1;
                        wdata_q <= rx_sh;
                        we_q    <= imm_hit(ptr);
                        wr_done <= 1'b1;
                        state   <= ST_WDATA_ACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_ID_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rw_q) begin
                        oe_q  <= ~reg_rdata[BYTE_W-1];
                        tx_sh <= {reg_rdata[BYTE_W-2:0], 1'b0};
                        state <= ST_RDATA;
                     end else begin
                        oe_q  <= 1'b0;
                        state <= ST_ADDR;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     oe_q   <= 1'b0;
                     bitcnt <= '0;
                     state  <= ST_WDATA;
                  end
               end
               ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     oe_q  <= 1'b0;
                     state <= ST_HOLD;
                  end
               end
               ST_HOLD: begin
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (byte_end) begin
                     oe_q   <= 1'b0;
                     bitcnt <= '0;
                     mack_q <= 1'b0;
                     state  <= ST_RD_ACK;
                  end else if (scl_fall) begin
                     oe_q  <= ~tx_sh[BYTE_W-1];
                     tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        oe_q  <= ~reg_rdata[BYTE_W-1];
                        tx_sh <= {reg_rdata[BYTE_W-2:0], 1'b0};
                        state <= ST_RDATA;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_oe     = oe_q;
   assign reg_we     = we_q;
   assign commit_stb = commit_q;
   assign reg_wdata  = wdata_q;
   assign reg_addr   = ptr;

endmodule

// File: rtl/tws_cmd_engine_chk.sv
// Property checker attached to the command engine.
module tws_cmd_engine_chk #(
   parameter logic [15:0] IMM_MASK = 16'h010F
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy_i,
   input logic       wr_permit,
   input logic       sda_oe,
   input logic       reg_we,
   input logic [7:0] reg_addr,
   input logic       commit_stb,
   input logic       scl_fall,
   input logic       stop_det
);

   // R11: the line is released while the device reports busy
   a_r11_busy_released: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy_i) |-> !sda_oe);

   // R5: write strobe follows a synchronised SCL falling edge
   a_r5_we_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(scl_fall));

   // R5: write strobe only for immediate addresses
   a_r5_we_imm_addr: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> ((reg_addr < 8'd16) && IMM_MASK[reg_addr[3:0]]));

   // R5: write strobe lasts one cycle
   a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R6: no write strobe without write permission
   a_r6_we_permit: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(wr_permit));

   // R7: commit strobe follows a STOP and lasts one cycle
   a_r7_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      commit_stb |-> $past(stop_det));

   a_r7_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
      commit_stb |=> !commit_stb);

endmodule

bind tws_cmd_engine tws_cmd_engine_chk #(
   .IMM_MASK (IMM_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_i     (busy_i),
   .wr_permit  (wr_permit),
   .sda_oe     (sda_oe),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .commit_stb (commit_stb),
   .scl_fall   (scl_fall),
   .stop_det   (stop_det)
);

// File: tb/tws_cmd_engine_tb.sv
module tws_cmd_engine_tb;

   localparam int Q = 8;
   localparam logic [2:0] STRAP = 3'b101;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       wr_permit = 1'b1;
   logic       busy_i = 1'b0;
   logic       sda_oe;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic       reg_we, commit_stb;
   wire        sda_bus = sda_m & ~sda_oe;

   logic [7:0] bank [256];
   logic [7:0] mdl  [256];
   int         we_cnt = 0, commit_cnt = 0;
   logic [7:0] c_addr, c_data;
   bit         oe_in_busy = 1'b0;
   int         checks = 0, fails = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   tws_cmd_engine u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_bus),
      .sda_oe     (sda_oe),
      .strap_addr (STRAP),
      .wr_permit  (wr_permit),
      .busy_i     (busy_i),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_we     (reg_we),
      .reg_rdata  (reg_rdata),
      .commit_stb (commit_stb)
   );

   function automatic logic [7:0] init_val(input int i);
      return 8'((i * 7) + 3);
   endfunction

   // Register bank model at the port
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) bank[i] <= init_val(i);
      end else if (reg_we) begin
         bank[reg_addr] <= reg_wdata;
      end
      if (reg_we) we_cnt <= we_cnt + 1;
      if (commit_stb) begin
         commit_cnt <= commit_cnt + 1;
         c_addr <= reg_addr;
         c_data <= reg_wdata;
      end
      if (busy_i && sda_oe) oe_in_busy <= 1'b1;
   end

   assign reg_rdata = bank[reg_addr];

   function automatic bit is_imm(input logic [7:0] a);
      return (a <= 8'd3) || (a == 8'd8);
   endfunction

   function automatic logic [7:0] nxt_ptr(input logic [7:0] p);
      return (p == 8'd8) ? 8'd0 : p + 8'd1;
   endfunction

   function automatic logic [7:0] id_byte(input bit rd);
      return {4'b1010, STRAP, rd};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic m_start();
      tick(2); sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0;
   endtask

   task automatic m_stop();
      tick(2); sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic m_send(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         tick(2); sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(Q);
         scl_m = 1'b0;
      end
      tick(2); sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q / 2);
      ack = !sda_bus;
      tick(Q / 2);
      scl_m = 1'b0;
   endtask

   task automatic m_recv(input bit give_ack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         tick(2 + Q);
         scl_m = 1'b1; tick(Q / 2);
         b[i] = sda_bus;
         tick(Q / 2);
         scl_m = 1'b0;
      end
      tick(2); sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0;
      tick(2); sda_m = 1'b1;
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d,
                           output bit ida, output bit aa, output bit da);
      m_start();
      m_send(id_byte(1'b0), ida);
      m_send(a, aa);
      m_send(d, da);
      m_stop();
   endtask

   task automatic do_read(input logic [7:0] a, input int n, input string tag);
      bit ack;
      logic [7:0] p, got;
      m_start();
      m_send(id_byte(1'b0), ack);
      check(ack, "R3 read header ack", ack, 1);
      m_send(a, ack);
      m_start();
      m_send(id_byte(1'b1), ack);
      check(ack, "R2 read id ack", ack, 1);
      p = a;
      for (int k = 0; k < n; k++) begin
         m_recv(k < n - 1, got);
         check(got == mdl[p], tag, got, mdl[p]);
         p = nxt_ptr(p);
      end
      m_stop();
   endtask

   // Expectation bookkeeping for one write
   task automatic write_checked(input logic [7:0] a, input logic [7:0] d, input bit perm);
      bit ida, aa, da;
      int we0, cm0;
      we0 = we_cnt; cm0 = commit_cnt;
      wr_permit = perm;
      do_write(a, d, ida, aa, da);
      tick(4);
      check(ida, "R2 id ack", ida, 1);
      check(aa, "R3 addr ack", aa, 1);
      check(da == perm, perm ? "R4 data ack" : "R6 data nack", da, perm);
      check(we_cnt - we0 == int'(perm && is_imm(a)), "R5 reg_we count", we_cnt - we0,
            int'(perm && is_imm(a)));
      check(commit_cnt - cm0 == int'(perm), "R7 commit count", commit_cnt - cm0, int'(perm));
      if (perm && is_imm(a)) mdl[a] = d;
      check(bank[a] == mdl[a], "R5 bank content", bank[a], mdl[a]);
      wr_permit = 1'b1;
   endtask

   initial begin
      bit ack, ida, aa, da;
      logic [7:0] got;
      int we0, cm0;
      void'($urandom(32'h00C0FFEE));
      for (int i = 0; i < 256; i++) mdl[i] = init_val(i);
      tick(5);
      check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
      check(reg_we == 1'b0, "R1 reset reg_we", reg_we, 0);
      check(commit_stb == 1'b0, "R1 reset commit", commit_stb, 0);
      rst_n = 1'b1;
      tick(5);

      // R5/R7 immediate address write
      write_checked(8'd2, 8'h5A, 1'b1);
      check(c_addr == 8'd2 && c_data == 8'h5A, "R7 commit addr/data", c_addr, 2);
      // R7 deferred address write: commit only
      write_checked(8'd5, 8'hC3, 1'b1);
      check(c_addr == 8'd5 && c_data == 8'hC3, "R7 deferred commit", c_data, 8'hC3);
      // R5 address 8 is immediate
      write_checked(8'd8, 8'h81, 1'b1);
      // R6 write protected
      write_checked(8'd1, 8'h33, 1'b0);

      // R2 wrong prefix and wrong strap
      m_start(); m_send(8'hB0 | {4'h0, STRAP, 1'b0}, ack); m_stop();
      check(!ack, "R2 wrong prefix nack", ack, 0);
      m_start(); m_send({4'b1010, ~STRAP, 1'b0}, ack); m_send(8'd0, aa); m_stop();
      check(!ack, "R2 wrong strap nack", ack, 0);
      check(!aa, "R2 idle after mismatch", aa, 0);

      // R12 surplus byte after accepted data
      we0 = we_cnt;
      m_start(); m_send(id_byte(1'b0), ida); m_send(8'd3, aa);
      m_send(8'h11, da); m_send(8'h22, ack); m_stop();
      tick(4);
      mdl[3] = 8'h11;
      check(!ack, "R12 surplus nack", ack, 0);
      check(we_cnt - we0 == 1, "R12 single write", we_cnt - we0, 1);
      check(bank[3] == 8'h11, "R12 bank keeps first", bank[3], 8'h11);

      // R1 clocks with no START get no ack
      m_send(id_byte(1'b0), ack); m_stop();
      check(!ack, "R1 idle without start", ack, 0);

      // R8/R9/R10 reads across the wrap
      do_read(8'd7, 4, "R9 wrap read");
      do_read(8'd8, 2, "R9 wrap at top");
      do_read(8'd0, 3, "R8 read data");

      // R10 master NACK releases the line
      m_start(); m_send(id_byte(1'b0), ack); m_send(8'd2, ack);
      m_start(); m_send(id_byte(1'b1), ack);
      m_recv(1'b0, got);
      check(got == mdl[2], "R10 last byte", got, mdl[2]);
      tick(2 + Q); scl_m = 1'b1; tick(Q / 2);
      check(sda_bus == 1'b1, "R10 released after nack", sda_bus, 1);
      tick(Q / 2); scl_m = 1'b0;
      m_stop();

      // R11 busy ignores START
      we0 = we_cnt; cm0 = commit_cnt;
      busy_i = 1'b1; tick(4);
      do_write(8'd0, 8'h77, ida, aa, da);
      tick(4);
      check(!ida, "R11 busy id nack", ida, 0);
      check(!oe_in_busy, "R11 no drive while busy", oe_in_busy, 0);
      check(we_cnt == we0 && commit_cnt == cm0, "R11 no strobes", we_cnt - we0, 0);
      busy_i = 1'b0; tick(4);

      // Seeded random traffic
      for (int t = 0; t < 30; t++) begin
         int r;
         logic [7:0] a;
         r = int'($urandom % 11);
         a = (r < 10) ? 8'(r) : 8'd20;
         if ($urandom % 2 == 0)
            write_checked(a, 8'($urandom), ($urandom % 5) != 0);
         else
            do_read(a, 1 + int'($urandom % 4), "R9 random read");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule